// File: doc/BRIEF.md
# Zero-Overhead Strip-Mining Loop Controller

This block runs a hardware loop around a strip-mined vector body without any branch instruction. Software loads a start address, an end address and a terminator register index, then arms the loop. Each time the fetch PC reaches the end address while the loop is armed, the block reads the terminator register. If the terminator is non-zero, the block overrides the next PC with the start address in that same cycle. If it is zero, fetch falls through past the end address and the loop disarms itself.

Up to `NBIND` auto-increment bindings can be active at once. Each binding names a target register, a step register and a small constant scale. On every pass through the end address, including the final one, each enabled binding writes `target + step * scale` back to its target register in the same cycle. The step register is usually the granted vector length, which the body sets afresh on every iteration. The address pointers therefore advance by however many elements the body actually processed.

Configuration uses a simple write port. Register-file access uses combinational read ports (one for the terminator, two per binding) and one write port per binding. The read ports are expected to return the register file's current contents in the same cycle.

Top module: `zol_strip_ctrl`

## Requirements
- R1: After reset the loop is disarmed, `redirect_o` is 0 and every `rf_we_o` bit is 0.
- R2: A configuration write (`cfg_we_i`) selects its field with `cfg_addr_i`, as follows. Address 0 is the start address and address 1 is the end address. Address 2 is the terminator register index, taken from bits [RW-1:0]. Address 3 is the arm flag: bit 0 = 1 arms the loop and 0 disarms it. Address 4+k is binding k, with the target index in [RW-1:0], the step index in [2RW-1:RW], the scale in [2RW+SW-1:2RW] and the enable in bit 31. The read address outputs always show the configured indices.
- R3: When the loop is armed, `pc_valid_i` is 1, `pc_i` equals the end address and the terminator data is non-zero, `redirect_o` is 1 and `redirect_pc_o` equals the start address in that same cycle. The loop stays armed.
- R4: At an armed end-address pass with a terminator value of zero, `redirect_o` stays 0. The loop is disarmed from the next cycle on, so a later pass at the end address does nothing.
- R5: At every armed end-address pass (loop-back or exit), each enabled binding k asserts `rf_we_o[k]`, with `rf_waddr_o[k]` set to its target index and `rf_wdata_o[k]` = target data + step data × scale, modulo 2^32.
- R6: A binding whose enable bit is 0 never asserts its write enable.
- R7: When the loop is disarmed, or `pc_valid_i` is 0, or `pc_i` differs from the end address, `redirect_o` and all `rf_we_o` bits are 0.
- R8: Two enabled bindings update independently in the same cycle, each with its own target, step and scale.
- R9: A configuration write to the arm field in the same cycle as an exit pass takes priority over the self-disarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration field select |
| cfg_wdata_i | input | XLEN | Configuration write data |
| pc_valid_i | input | 1 | Current PC is valid this cycle |
| pc_i | input | XLEN | Current fetch PC |
| term_raddr_o | output | RW | Terminator register read index |
| term_rdata_i | input | XLEN | Terminator register value |
| step_raddr_o | output | NBIND×RW | Step register read index per binding |
| step_rdata_i | input | NBIND×XLEN | Step register value per binding |
| tgt_raddr_o | output | NBIND×RW | Target register read index per binding |
| tgt_rdata_i | input | NBIND×XLEN | Target register value per binding |
| rf_we_o | output | NBIND | Register write enable per binding |
| rf_waddr_o | output | NBIND×RW | Register write index per binding |
| rf_wdata_o | output | NBIND×XLEN | Register write data per binding |
| redirect_o | output | 1 | Override next PC |
| redirect_pc_o | output | XLEN | Next PC when overriding |

## Verification
The bench builds the block with RW=3 (eight registers), two bindings, a 4-bit scale and 32-bit data, so that a small model register file fits in the bench. This makes it possible to sweep every scale value against step values that include zero, one and all-ones. The all-ones step and a target near 2^32 exercise the wrap. A full strip-mined loop (a count of 10 with a maximum vector length of 4, so the last strip is partial) drives both bindings at different scales. It checks the loop-back and exit decisions and the final pointer values against sums computed in the bench.

// File: rtl/zol_pkg.sv
package zol_pkg;
  localparam int CFG_AW = 3;
  typedef enum logic [CFG_AW-1:0] {
    CFG_START = 3'd0,
    CFG_END   = 3'd1,
    CFG_TERM  = 3'd2,
    CFG_ARM   = 3'd3,
    CFG_BIND0 = 3'd4
  } cfg_field_e;
endpackage

// File: rtl/zol_cfg.sv
module zol_cfg
  import zol_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int RW    = 5,
  parameter int SW    = 4,
  parameter int NBIND = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cfg_we_i,
  input  logic [CFG_AW-1:0]          cfg_addr_i,
  input  logic [XLEN-1:0]            cfg_wdata_i,
  input  logic                       exit_i,
  output logic [XLEN-1:0]            start_o,
  output logic [XLEN-1:0]            end_o,
  output logic [RW-1:0]              term_o,
  output logic                       armed_o,
  output logic [NBIND-1:0]           bind_en_o,
  output logic [NBIND-1:0][RW-1:0]   bind_tgt_o,
  output logic [NBIND-1:0][RW-1:0]   bind_step_o,
  output logic [NBIND-1:0][SW-1:0]   bind_scale_o
);
  localparam int SCL_LO = 2 * RW;

  logic arm_wr;
  assign arm_wr = cfg_we_i && (cfg_addr_i == CFG_ARM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o <= '0;
      end_o   <= '0;
      term_o  <= '0;
      armed_o <= 1'b0;
    end else begin
      if (cfg_we_i && cfg_addr_i == CFG_START) start_o <= cfg_wdata_i;
      if (cfg_we_i && cfg_addr_i == CFG_END)   end_o   <= cfg_wdata_i;
      if (cfg_we_i && cfg_addr_i == CFG_TERM)  term_o  <= cfg_wdata_i[RW-1:0];
      // explicit arm write beats self-disarm
      if (arm_wr)      armed_o <= cfg_wdata_i[0];
      else if (exit_i) armed_o <= 1'b0;
    end
  end

  for (genvar k = 0; k < NBIND; k++) begin : g_bind
    logic sel;
    assign sel = cfg_we_i && (cfg_addr_i == CFG_AW'(CFG_BIND0 + k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bind_en_o[k]    <= 1'b0;
        bind_tgt_o[k]   <= '0;
        bind_step_o[k]  <= '0;
        bind_scale_o[k] <= '0;
      end else if (sel) begin
        bind_en_o[k]    <= cfg_wdata_i[XLEN-1];
        bind_tgt_o[k]   <= cfg_wdata_i[RW-1:0];
        bind_step_o[k]  <= cfg_wdata_i[2*RW-1:RW];
        bind_scale_o[k] <= cfg_wdata_i[SCL_LO+SW-1:SCL_LO];
      end
    end
  end

  a_r9_arm_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_wr |=> armed_o == $past(cfg_wdata_i[0]));
  a_r4_exit_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exit_i && !arm_wr) |=> !armed_o);
endmodule

// File: rtl/zol_autoinc.sv
module zol_autoinc #(
  parameter int XLEN = 32,
  parameter int RW   = 5,
  parameter int SW   = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hit_i,
  input  logic            en_i,
  input  logic [RW-1:0]   tgt_idx_i,
  input  logic [RW-1:0]   step_idx_i,
  input  logic [SW-1:0]   scale_i,
  input  logic [XLEN-1:0] tgt_rdata_i,
  input  logic [XLEN-1:0] step_rdata_i,
  output logic [RW-1:0]   tgt_raddr_o,
  output logic [RW-1:0]   step_raddr_o,
  output logic            we_o,
  output logic [RW-1:0]   waddr_o,
  output logic [XLEN-1:0] wdata_o
);
  logic [XLEN-1:0] delta;

  assign tgt_raddr_o  = tgt_idx_i;
  assign step_raddr_o = step_idx_i;
  assign delta        = step_rdata_i * XLEN'(scale_i);
  assign we_o         = hit_i && en_i;
  assign waddr_o      = tgt_idx_i;
  assign wdata_o      = tgt_rdata_i + delta;

  a_r6_disabled_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !we_o);
  a_r5_zero_step_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && step_rdata_i == '0) |-> wdata_o == tgt_rdata_i);
endmodule

// File: rtl/zol_strip_ctrl.sv
module zol_strip_ctrl
  import zol_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int RW    = 5,
  parameter int SW    = 4,
  parameter int NBIND = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cfg_we_i,
  input  logic [CFG_AW-1:0]          cfg_addr_i,
  input  logic [XLEN-1:0]            cfg_wdata_i,
  input  logic                       pc_valid_i,
  input  logic [XLEN-1:0]            pc_i,
  output logic [RW-1:0]              term_raddr_o,
  input  logic [XLEN-1:0]            term_rdata_i,
  output logic [NBIND-1:0][RW-1:0]   step_raddr_o,
  input  logic [NBIND-1:0][XLEN-1:0] step_rdata_i,
  output logic [NBIND-1:0][RW-1:0]   tgt_raddr_o,
  input  logic [NBIND-1:0][XLEN-1:0] tgt_rdata_i,
  output logic [NBIND-1:0]           rf_we_o,
  output logic [NBIND-1:0][RW-1:0]   rf_waddr_o,
  output logic [NBIND-1:0][XLEN-1:0] rf_wdata_o,
  output logic                       redirect_o,
  output logic [XLEN-1:0]            redirect_pc_o
);
  logic [XLEN-1:0]           start_q, end_q;
  logic [RW-1:0]             term_q;
  logic                      armed_q;
  logic [NBIND-1:0]          bind_en;
  logic [NBIND-1:0][RW-1:0]  bind_tgt, bind_step;
  logic [NBIND-1:0][SW-1:0]  bind_scale;
  logic                      hit, term_zero, exit_pass;

  assign hit       = armed_q && pc_valid_i && (pc_i == end_q);
  assign term_zero = (term_rdata_i == '0);
  assign exit_pass = hit && term_zero;

  zol_cfg #(.XLEN(XLEN), .RW(RW), .SW(SW), .NBIND(NBIND)) u_cfg (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .exit_i       (exit_pass),
    .start_o      (start_q),
    .end_o        (end_q),
    .term_o       (term_q),
    .armed_o      (armed_q),
    .bind_en_o    (bind_en),
    .bind_tgt_o   (bind_tgt),
    .bind_step_o  (bind_step),
    .bind_scale_o (bind_scale)
  );

  for (genvar k = 0; k < NBIND; k++) begin : g_inc
    zol_autoinc #(.XLEN(XLEN), .RW(RW), .SW(SW)) u_inc (
      .clk_i, .rst_ni,
      .hit_i        (hit),
      .en_i         (bind_en[k]),
      .tgt_idx_i    (bind_tgt[k]),
      .step_idx_i   (bind_step[k]),
      .scale_i      (bind_scale[k]),
      .tgt_rdata_i  (tgt_rdata_i[k]),
      .step_rdata_i (step_rdata_i[k]),
      .tgt_raddr_o  (tgt_raddr_o[k]),
      .step_raddr_o (step_raddr_o[k]),
      .we_o         (rf_we_o[k]),
      .waddr_o      (rf_waddr_o[k]),
      .wdata_o      (rf_wdata_o[k])
    );
  end

  assign term_raddr_o  = term_q;
  assign redirect_o    = hit && !term_zero;
  assign redirect_pc_o = start_q;

  a_r3_redirect_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> (pc_valid_i && pc_i == end_q && term_rdata_i != '0));
  a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q || !pc_valid_i) |-> (!redirect_o && rf_we_o == '0));
  a_r3_stays_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && !cfg_we_i) |=> armed_q);
  a_r5_writes_on_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o != '0) |-> (pc_valid_i && pc_i == end_q));
endmodule

// File: tb/zol_strip_ctrl_test.sv
`timescale 1ns/1ps
module zol_strip_ctrl_test;
  localparam int XLEN = 32, RW = 3, SW = 4, NB = 2, NR = 1 << RW;
  localparam logic [XLEN-1:0] START = 32'h0000_1000, ENDA = 32'h0000_1020;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic                     cfg_we = 0;
  logic [2:0]               cfg_addr = '0;
  logic [XLEN-1:0]          cfg_data = '0;
  logic                     pc_valid = 0;
  logic [XLEN-1:0]          pc = '0;
  logic [RW-1:0]            term_ra;
  logic [XLEN-1:0]          term_rd;
  logic [NB-1:0][RW-1:0]    step_ra, tgt_ra, waddr;
  logic [NB-1:0][XLEN-1:0]  step_rd, tgt_rd, wdata;
  logic [NB-1:0]            we;
  logic                     redir;
  logic [XLEN-1:0]          redir_pc;
  logic [XLEN-1:0]          rf [NR];

  int n_chk = 0, n_fail = 0;

  zol_strip_ctrl #(.XLEN(XLEN), .RW(RW), .SW(SW), .NBIND(NB)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_data), .pc_valid_i(pc_valid), .pc_i(pc),
    .term_raddr_o(term_ra), .term_rdata_i(term_rd),
    .step_raddr_o(step_ra), .step_rdata_i(step_rd),
    .tgt_raddr_o(tgt_ra), .tgt_rdata_i(tgt_rd),
    .rf_we_o(we), .rf_waddr_o(waddr), .rf_wdata_o(wdata),
    .redirect_o(redir), .redirect_pc_o(redir_pc));

  assign term_rd = rf[term_ra];
  for (genvar k = 0; k < NB; k++) begin : g_rd
    assign step_rd[k] = rf[step_ra[k]];
    assign tgt_rd[k]  = rf[tgt_ra[k]];
  end
  always @(posedge clk) for (int k = 0; k < NB; k++) if (we[k]) rf[waddr[k]] <= wdata[k];

  task automatic chk(input bit ok, input string req, input logic [XLEN-1:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [2:0] a, input logic [XLEN-1:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_data = d;
    @(negedge clk); cfg_we = 0;
  endtask

  function automatic logic [XLEN-1:0] bword(bit en, int tgt, int stp, int scl);
    return {en, 31'(0)} | XLEN'(scl << (2*RW)) | XLEN'(stp << RW) | XLEN'(tgt);
  endfunction

  // drive pc at negedge, sample 1 ns later, before posedge
  task automatic at_pc(input logic v, input logic [XLEN-1:0] p);
    @(negedge clk); pc_valid = v; pc = p; #1;
  endtask

  task automatic pc_idle();
    @(negedge clk); pc_valid = 0; pc = '0;
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [XLEN-1:0] e0, e1, cnt, vl, p2, p3;
    for (int r = 0; r < NR; r++) rf[r] = '0;
    #12 rst_n = 1;
    @(negedge clk); #1;
    chk(!redir, "R1 redirect", XLEN'(redir), 0);
    chk(we == '0, "R1 we", XLEN'(we), 0);

    cfg_wr(0, START); cfg_wr(1, ENDA); cfg_wr(2, 1);
    cfg_wr(4, bword(1, 3, 2, 4));
    chk(term_ra == 1, "R2 term idx", XLEN'(term_ra), 1);
    chk(tgt_ra[0] == 3 && step_ra[0] == 2, "R2 bind idx", XLEN'({tgt_ra[0], step_ra[0]}), 32'h1a);

    // not armed yet
    rf[1] = 5;
    at_pc(1, ENDA);
    chk(!redir && we == '0, "R7 disarmed", XLEN'({redir, we}), 0);
    cfg_wr(3, 1);
    at_pc(1, ENDA + 4);
    chk(!redir && we == '0, "R7 other pc", XLEN'({redir, we}), 0);
    at_pc(0, ENDA);
    chk(!redir && we == '0, "R7 pc invalid", XLEN'({redir, we}), 0);
    pc_idle();

    // R5 sweep over all scales and edge step values
    rf[3] = 32'hFFFF_FFF0;
    for (int s = 0; s < 16; s++) begin
      for (int j = 0; j < 4; j++) begin
        logic [XLEN-1:0] sv;
        sv = (j == 0) ? 0 : (j == 1) ? 1 : (j == 2) ? 7 : 32'hFFFF_FFFF;
        cfg_wr(4, bword(1, 3, 2, s));
        rf[2] = sv;
        e0 = rf[3] + sv * XLEN'(s);
        at_pc(1, ENDA);
        chk(we[0] && waddr[0] == 3 && wdata[0] == e0, "R5 scaled add", wdata[0], e0);
        chk(redir && redir_pc == START, "R3 loop back", redir_pc, START);
        @(posedge clk); #0.5;
        chk(rf[3] == e0, "R5 written", rf[3], e0);
        pc_idle();
      end
    end

    // R6 disabled binding, target untouched
    cfg_wr(4, bword(0, 3, 2, 4));
    e0 = rf[3];
    at_pc(1, ENDA);
    chk(we[0] == 0, "R6 no we", XLEN'(we[0]), 0);
    @(posedge clk); #0.5;
    chk(rf[3] == e0, "R6 target kept", rf[3], e0);
    pc_idle();

    // R8/R3/R4 full strip-mined loop, count 10, max vl 4
    cfg_wr(4, bword(1, 3, 2, 4));
    cfg_wr(5, bword(1, 4, 2, 8));
    rf[3] = 32'h100; rf[4] = 32'h800; rf[1] = 10;
    cnt = 10; p2 = 32'h100; p3 = 32'h800;
    while (cnt != 0) begin
      @(negedge clk); pc_valid = 0;
      vl = (cnt > 4) ? 4 : cnt;
      rf[2] = vl; cnt = cnt - vl; rf[1] = cnt;
      e0 = p2 + vl * 4; e1 = p3 + vl * 8;
      at_pc(1, ENDA);
      chk(redir == (cnt != 0), (cnt != 0) ? "R3 loop back" : "R4 exit", XLEN'(redir), XLEN'(cnt != 0));
      chk(we == 2'b11 && wdata[0] == e0 && wdata[1] == e1, "R8 both bindings", wdata[1], e1);
      p2 = e0; p3 = e1;
    end
    pc_idle();
    chk(rf[3] == 32'h128 && rf[4] == 32'h850, "R8 final pointers", rf[4], 32'h850);
    rf[1] = 3;
    at_pc(1, ENDA);
    chk(!redir && we == '0, "R4 disarmed after exit", XLEN'({redir, we}), 0);
    pc_idle();

    // R9 arm write in exit cycle wins
    cfg_wr(3, 1);
    rf[1] = 0;
    @(negedge clk); pc_valid = 1; pc = ENDA; cfg_we = 1; cfg_addr = 3; cfg_data = 1;
    @(negedge clk); cfg_we = 0; rf[1] = 2; #1;
    chk(redir, "R9 still armed", XLEN'(redir), 1);
    pc_idle();

    // R1 reset again
    rst_n = 0; #3; rst_n = 1;
    at_pc(1, ENDA);
    chk(!redir && we == '0, "R1 after reset", XLEN'({redir, we}), 0);
    pc_idle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule